// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This is a purely combinational 32-bit datapath. It adds or subtracts two source words lane by lane. The word is split either into four 8-bit lanes or into two 16-bit lanes. Each lane is computed on its own, in signed or unsigned arithmetic. The truncated lane results are packed back into their original positions to form the result word.

Beside the result, the unit produces a 4-bit greater-or-equal flag vector with one flag per byte position. Every flag is written on every operation. The rule that sets a flag depends on the mode:

- **Unsigned add:** the flag is set on carry out of the lane.
- **Unsigned subtract:** the flag is set when the lane produces no borrow.
- **Signed operations:** the flag is set when the full-precision lane result is non-negative.

In halfword mode each halfword drives a pair of flags. A surrounding execute stage places the operands and mode selects on the inputs. It takes the result and the flags in the same cycle.

Top module: `simd_addsub`

## Requirements
- R1: With `size_i`=0 (byte lanes), result byte k (bits 8k+7..8k) equals operand byte k of `a_i` plus or minus operand byte k of `b_i`, truncated to 8 bits. No carry or borrow crosses into another lane.
- R2: With `size_i`=1 (halfword lanes), result bits 15..0 and 31..16 are each the 16-bit truncated sum or difference of the matching operand halves. Nothing crosses between the halves.
- R3: Unsigned add (`signed_i`=0, `sub_i`=0) sets a lane's flag when the lane sum exceeds the lane's maximum unsigned value (carry out). Otherwise it clears the flag.
- R4: Unsigned subtract (`signed_i`=0, `sub_i`=1) sets a lane's flag when the `a_i` lane is greater than or equal to the `b_i` lane (no borrow). Otherwise it clears the flag.
- R5: Signed add or subtract (`signed_i`=1) sets a lane's flag when the full-precision signed result (9 bits for bytes, 17 bits for halves) is greater than or equal to zero. The flag is not taken from the top bit of the truncated result.
- R6: In halfword mode `ge_o[1:0]` both carry the low half's flag and `ge_o[3:2]` both carry the high half's flag. In byte mode `ge_o[k]` belongs to byte lane k.
- R7: All four flags and the result depend only on the present inputs. No flag keeps a value from an earlier operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First source word (minuend for subtract) |
| b_i | input | 32 | Second source word (subtrahend for subtract) |
| size_i | input | 1 | Lane size: 0 selects byte lanes, 1 selects halfword lanes |
| sub_i | input | 1 | 0 adds, 1 subtracts |
| signed_i | input | 1 | 0 unsigned, 1 signed (two's complement) |
| res_o | output | 32 | Packed lane results |
| ge_o | output | 4 | Greater-or-equal flags, one per byte position |

## Verification
The embedded checks are immediate and take for granted that all five inputs carry known 0/1 values whenever the combinational logic settles. They hold for any operand value and any mode. The bench therefore drives every input from reset time onward and never leaves one undriven or X. It changes the inputs only just after a clock edge and samples the outputs half a period later, so every check sees settled logic. Operands sweep every value of the first lane against a fixed set of corner and mixed values, including 0x00, 0x7F, 0x80 and 0xFF and their halfword counterparts. Each word is run in all eight mode combinations.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;
  typedef enum logic {
    LANE_BYTE = 1'b0,
    LANE_HALF = 1'b1
  } lane_size_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         signed_i,
  output logic [W-1:0] res_o,
  output logic         ge_o
);
  logic [W:0] a_x, b_x, sum;
  logic signed [W+1:0] chk_wide;

  always_comb begin
    // one extra bit: sign extension in signed mode, zero otherwise
    a_x   = {signed_i & a_i[W-1], a_i};
    b_x   = {signed_i & b_i[W-1], b_i};
    sum   = sub_i ? (a_x - b_x) : (a_x + b_x);
    res_o = sum[W-1:0];
    // carry for unsigned add; borrow-free / non-negative otherwise
    ge_o  = (!signed_i && !sub_i) ? sum[W] : !sum[W];
  end

  always_comb begin
    chk_wide = sub_i ? ($signed(a_i) - $signed(b_i)) : ($signed(a_i) + $signed(b_i));
    if (!signed_i && !sub_i)
      assert_carry_out_R3: assert ({ge_o, res_o} == ({1'b0, a_i} + {1'b0, b_i}));
    if (!signed_i && sub_i)
      assert_no_borrow_R4: assert (ge_o == (a_i >= b_i));
    if (signed_i)
      assert_non_negative_R5: assert (ge_o == (chk_wide >= 0));
    if (signed_i)
      assert_trunc_signed_R1: assert (res_o == chk_wide[W-1:0]);
  end
endmodule

// File: rtl/simd_ge_expand.sv
module simd_ge_expand #(
  parameter int unsigned NB = 4,
  localparam int unsigned NH = NB / 2
) (
  input  simd_addsub_pkg::lane_size_e size_i,
  input  logic [NB-1:0]               byte_ge_i,
  input  logic [NH-1:0]               half_ge_i,
  output logic [NB-1:0]               ge_o
);
  logic [NB-1:0] half_pairs;

  for (genvar h = 0; h < NH; h++) begin : g_pair
    assign half_pairs[2*h+1:2*h] = {2{half_ge_i[h]}};

    always_comb begin
      if (size_i == simd_addsub_pkg::LANE_HALF)
        assert_pair_equal_R6: assert (ge_o[2*h] == ge_o[2*h+1]);
    end
  end

  assign ge_o = (size_i == simd_addsub_pkg::LANE_HALF) ? half_pairs : byte_ge_i;
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NB     = DATA_W / BYTE_W,
  localparam int unsigned HALF_W = 2 * BYTE_W,
  localparam int unsigned NH     = NB / 2
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              size_i,
  input  logic              sub_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NB-1:0]     ge_o
);
  import simd_addsub_pkg::*;

  lane_size_e        size_sel;
  logic [DATA_W-1:0] byte_res, half_res;
  logic [NB-1:0]     byte_ge;
  logic [NH-1:0]     half_ge;

  assign size_sel = lane_size_e'(size_i);

  for (genvar k = 0; k < NB; k++) begin : g_byte
    simd_lane #(.W(BYTE_W)) u_lane (
      .a_i      (a_i[k*BYTE_W +: BYTE_W]),
      .b_i      (b_i[k*BYTE_W +: BYTE_W]),
      .sub_i    (sub_i),
      .signed_i (signed_i),
      .res_o    (byte_res[k*BYTE_W +: BYTE_W]),
      .ge_o     (byte_ge[k])
    );
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    simd_lane #(.W(HALF_W)) u_lane (
      .a_i      (a_i[h*HALF_W +: HALF_W]),
      .b_i      (b_i[h*HALF_W +: HALF_W]),
      .sub_i    (sub_i),
      .signed_i (signed_i),
      .res_o    (half_res[h*HALF_W +: HALF_W]),
      .ge_o     (half_ge[h])
    );
  end

  simd_ge_expand #(.NB(NB)) u_ge (
    .size_i    (size_sel),
    .byte_ge_i (byte_ge),
    .half_ge_i (half_ge),
    .ge_o      (ge_o)
  );

  assign res_o = (size_sel == LANE_HALF) ? half_res : byte_res;

  always_comb begin
    if (size_sel == LANE_BYTE && !sub_i && !signed_i)
      assert_byte_isolated_R1: assert (res_o[BYTE_W-1:0] == BYTE_W'(a_i[BYTE_W-1:0] + b_i[BYTE_W-1:0]));
    if (size_sel == LANE_HALF && sub_i && !signed_i)
      assert_half_isolated_R2: assert (res_o[DATA_W-1:HALF_W] == (DATA_W-HALF_W)'(a_i[DATA_W-1:HALF_W] - b_i[DATA_W-1:HALF_W]));
  end
endmodule

// File: tb/simd_addsub_tb_top.sv
module simd_addsub_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic size, sub, sgn;
  logic [3:0] ge;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_addsub dut_i (
    .a_i(a), .b_i(b), .size_i(size), .sub_i(sub), .signed_i(sgn),
    .res_o(res), .ge_o(ge)
  );

  function automatic logic [7:0] bpick(int i);
    case (i & 15)
      0: return 8'h00;  1: return 8'h7F;  2: return 8'h80;  3: return 8'hFF;
      4: return 8'h01;  5: return 8'hFE;  6: return 8'h7E;  7: return 8'h81;
      8: return 8'h40;  9: return 8'hC0; 10: return 8'h10; 11: return 8'hF0;
      12: return 8'h55; 13: return 8'hAA; 14: return 8'h3C; default: return 8'hC3;
    endcase
  endfunction

  // lane-wise reference: full-precision integer arithmetic
  task automatic ref_model(input logic [31:0] ra, input logic [31:0] rb,
                           input logic rs, input logic rsub, input logic rsg,
                           output logic [31:0] eres, output logic [3:0] ege);
    int w = rs ? 16 : 8;
    int n = rs ? 2 : 4;
    longint va, vb, r, lim;
    eres = '0; ege = '0;
    lim = longint'(1) << w;
    for (int k = 0; k < n; k++) begin
      va = longint'((ra >> (k*w))) & (lim - 1);
      vb = longint'((rb >> (k*w))) & (lim - 1);
      if (rsg) begin
        if (va >= lim/2) va -= lim;
        if (vb >= lim/2) vb -= lim;
      end
      r = rsub ? va - vb : va + vb;
      eres |= 32'((r & (lim - 1)) << (k*w));
      if (rs) begin
        if (!rsg && !rsub) ege[2*k +: 2] = (r >= lim) ? 2'b11 : 2'b00;
        else               ege[2*k +: 2] = (r >= 0)   ? 2'b11 : 2'b00;
      end else begin
        if (!rsg && !rsub) ege[k] = (r >= lim);
        else               ege[k] = (r >= 0);
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h size=%0b sub=%0b sgn=%0b actual=%h expected=%h",
               tag, a, b, size, sub, sgn, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] va, input logic [31:0] vb,
                         input logic vs, input logic vsub, input logic vsg);
    logic [31:0] eres;
    logic [3:0] ege;
    @(posedge clk);
    a = va; b = vb; size = vs; sub = vsub; sgn = vsg;
    @(negedge clk);
    ref_model(va, vb, vs, vsub, vsg, eres, ege);
    check(vs ? "R2 result" : "R1 result", res, eres);
    if (vsg)       check("R5 ge", {28'd0, ge}, {28'd0, ege});
    else if (vsub) check("R4 ge", {28'd0, ge}, {28'd0, ege});
    else           check("R3 ge", {28'd0, ge}, {28'd0, ege});
    if (vs) check("R6 pair", {30'd0, ge[1] ^ ge[0], ge[3] ^ ge[2]}, 32'd0);
  endtask

  initial begin
    a = '0; b = '0; size = 1'b0; sub = 1'b0; sgn = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle result", res, 32'd0);
    check("R3 idle ge", {28'd0, ge}, 32'd0);

    // R5: 0x80 - 0x01 = -129, truncated 0x7F, flag must be 0
    run_vec(32'h8080_8080, 32'h0101_0101, 1'b0, 1'b1, 1'b1);
    check("R5 wide sign", {28'd0, ge}, 32'd0);
    // R3 carry in every byte, no cross-lane carry
    run_vec(32'hFFFF_FFFF, 32'h0101_0101, 1'b0, 1'b0, 1'b0);
    check("R1 no ripple", res, 32'd0);
    // R7: next operation clears all flags
    run_vec(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    check("R7 flags refreshed", {28'd0, ge}, 32'd0);
    // R2: halfword borrow stays in its half
    run_vec(32'h0001_0000, 32'h0000_0001, 1'b1, 1'b1, 1'b0);
    check("R2 no borrow ripple", res, 32'h0001_FFFF);
    check("R6 half flags", {28'd0, ge}, 32'h0000_000C);

    // halfword corners in both halves
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int m = 0; m < 4; m++) begin
          logic [15:0] hc [4];
          hc[0] = 16'h0000; hc[1] = 16'h7FFF; hc[2] = 16'h8000; hc[3] = 16'hFFFF;
          run_vec({hc[i], hc[j]}, {hc[j], hc[i]}, 1'b1, m[0], m[1]);
        end

    // near-exhaustive sweep: lane 0 sees every a value against 16 b values
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 16; ib++) begin
        logic [31:0] wa, wb;
        for (int k = 0; k < 4; k++) begin
          wa[8*k +: 8] = 8'((ia + k*67) & 255);
          wb[8*k +: 8] = bpick(ib + k*5);
        end
        for (int m = 0; m < 8; m++)
          run_vec(wa, wb, m[2], m[0], m[1]);
      end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule